// File: doc/BRIEF.md
# Ingress Traffic Class Classifier

This block watches the opening bytes of each frame entering a switch port and picks one of eight traffic classes for it. It follows the byte stream as it arrives and checks three things. The first three destination MAC bytes are compared against two reserved management prefixes. The two bytes at the tag position are compared against a programmable tag identifier. The priority bits that follow a recognised tag are captured.

A management frame always gets the highest class, whatever priority it carries. A frame with a recognised tag gets its class from the tag priority bits. Any other frame gets the port default priority. The result is strobed once per frame, as early as the header allows. The output holds until the next frame's result.

The byte input is a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, and every cycle with `in_valid` high transfers one byte. A source that wants to pause simply drops `in_valid`. Bytes are numbered from 0, and byte 0 is the byte that carries `in_sof`. The tag identifier and default priority inputs are plain configuration pins, sampled on the byte that uses them.

Top module: `tcc_classifier`

## Requirements
- R1: `in_ready` is 1 in every cycle, including reset, so a byte is accepted on every clock edge where `in_valid` is 1.
- R2: A byte carrying `in_sof` becomes byte 0 of a new frame. Valid bytes that arrive while no frame is open and that lack `in_sof` are ignored and produce no strobe.
- R3: `tc_done` pulses for exactly one cycle per frame, on the cycle after byte 14 is accepted or after a byte with `in_eof` is accepted, whichever comes first. Bytes after byte 14 and before the next `in_sof` produce no further strobe.
- R4: A frame has a recognised tag when byte 12 equals `tpid_cfg[15:8]` and byte 13 equals `tpid_cfg[7:0]`. Such a frame, if it is not a management frame, takes class `byte14[7:5]`.
- R5: A frame of at least 15 bytes whose bytes 12 and 13 do not match `tpid_cfg` (for example 0x8100 while 0xDADA is programmed) is untagged and takes class `default_prio`.
- R6: A frame whose bytes 0, 1, 2 equal 01 80 C2 or 01 19 1B is a management frame. It gets `tc_class` = 7 and `tc_mgmt` = 1, whatever tag or priority it carries. A frame that differs in any of those three bytes gets `tc_mgmt` = 0.
- R7: A frame that ends before byte 14 takes `default_prio`, unless it carried at least 3 bytes that match a management prefix, in which case R6 applies.
- R8: After reset `tc_class` = 0, `tc_mgmt` = 0 and `tc_done` = 0. `tc_class` and `tc_mgmt` hold their last strobed values between strobes.
- R9: An `in_sof` that arrives before the open frame has been strobed abandons that frame without a strobe and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_ready | output | 1 | Always 1; the block accepts every byte |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | This byte is byte 0 of a frame |
| in_eof | input | 1 | This byte is the last of the frame |
| tpid_cfg | input | 16 | Tag identifier recognised at bytes 12 and 13 |
| default_prio | input | 3 | Class for untagged, non-management frames |
| tc_class | output | 3 | Traffic class of the last strobed frame |
| tc_mgmt | output | 1 | Last strobed frame was a management frame |
| tc_done | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its default parameters. These are an 8-bit byte, a two-byte tag identifier at byte 12, priority bits at byte 14, and two three-byte management prefixes. With these values the whole decision window of 15 bytes can be reached with frames of 1 to 40 bytes.

Every edge of the window is exercised. This covers frames ending at bytes 0, 1, 2, 13, 14 and beyond, near-miss prefixes, a standard tag seen while a custom one is programmed, abandoned frames, and stray bytes outside a frame. Random idle gaps move the strobe cycle relative to the input stream.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int CLASS_W = 3;
  localparam int NUM_CLASSES = 1 << CLASS_W;

  typedef logic [CLASS_W-1:0] tc_class_t;

  typedef struct packed {
    tc_class_t cls;
    logic      mgmt;
  } tc_result_t;
endpackage

// File: rtl/tcc_byte_tracker.sv
module tcc_byte_tracker #(
  parameter int LAST_POS = 14,
  localparam int IDX_W = $clog2(LAST_POS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             sof,
  input  logic             eof,
  output logic [IDX_W-1:0] idx_cur,
  output logic             byte_live,
  output logic             final_byte
);
  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    idx_cur    = sof ? '0 : idx_q;
    byte_live  = accept && (sof || active_q);
    final_byte = byte_live && (eof || idx_cur == IDX_W'(LAST_POS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (final_byte) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (byte_live) begin
      active_q <= 1'b1;
      idx_q    <= idx_cur + IDX_W'(1);
    end
  end

  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(LAST_POS));

  assert_close_after_final_R3: assert property (@(posedge clk) disable iff (!rst_n)
    final_byte |=> !active_q);
endmodule

// File: rtl/tcc_mgmt_match.sv
module tcc_mgmt_match #(
  parameter int BYTE_W = 8,
  parameter int PREFIX_BYTES = 3,
  parameter int NUM_PREFIX = 2,
  parameter logic [NUM_PREFIX*PREFIX_BYTES*BYTE_W-1:0] PREFIX_TABLE = '0,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_live,
  input  logic [IDX_W-1:0]  idx_cur,
  input  logic [BYTE_W-1:0] in_data,
  output logic              match_now
);
  logic [NUM_PREFIX-1:0] hit_q;
  logic [NUM_PREFIX-1:0] cand;
  logic                  in_prefix;

  assign in_prefix = idx_cur < IDX_W'(PREFIX_BYTES);

  for (genvar p = 0; p < NUM_PREFIX; p++) begin : g_prefix
    logic [BYTE_W-1:0] ref_byte;
    always_comb begin
      ref_byte = '0;
      for (int k = 0; k < PREFIX_BYTES; k++) begin
        if (idx_cur == IDX_W'(k))
          ref_byte = PREFIX_TABLE[(p*PREFIX_BYTES + PREFIX_BYTES-1-k)*BYTE_W +: BYTE_W];
      end
      cand[p] = ((idx_cur == '0) || hit_q[p]) && (in_data == ref_byte);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= '0;
    else if (byte_live && in_prefix) hit_q <= cand;
  end

  always_comb begin
    if (idx_cur == IDX_W'(PREFIX_BYTES - 1)) match_now = |cand;
    else if (!in_prefix)                      match_now = |hit_q;
    else                                      match_now = 1'b0;
  end

  assert_match_needs_prefix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_live && match_now) |-> (idx_cur >= IDX_W'(PREFIX_BYTES - 1)));
endmodule

// File: rtl/tcc_tag_detect.sv
module tcc_tag_detect #(
  parameter int BYTE_W = 8,
  parameter int TAG_BYTES = 2,
  parameter int TAG_POS = 12,
  parameter int IDX_W = 4,
  localparam int TAG_W = TAG_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_live,
  input  logic [IDX_W-1:0]  idx_cur,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [TAG_W-1:0]  tpid_cfg,
  output logic              tag_seen
);
  logic              ok_q;
  logic [BYTE_W-1:0] want;
  logic              in_tag;

  always_comb begin
    want   = '0;
    in_tag = 1'b0;
    for (int k = 0; k < TAG_BYTES; k++) begin
      if (idx_cur == IDX_W'(TAG_POS + k)) begin
        want   = tpid_cfg[(TAG_BYTES-1-k)*BYTE_W +: BYTE_W];
        in_tag = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ok_q <= 1'b0;
    else if (byte_live && in_tag) begin
      if (idx_cur == IDX_W'(TAG_POS)) ok_q <= (in_data == want);
      else                            ok_q <= ok_q && (in_data == want);
    end
  end

  assign tag_seen = ok_q;
endmodule

// File: rtl/tcc_resolver.sv
module tcc_resolver
  import tcc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PCP_POS = 14,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              final_byte,
  input  logic [IDX_W-1:0]  idx_cur,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              mgmt_hit,
  input  logic              tag_seen,
  input  tc_class_t         default_prio,
  output tc_class_t         tc_class,
  output logic              tc_mgmt,
  output logic              tc_done
);
  tc_result_t res_d, res_q;
  logic       done_q;
  logic       pcp_ok;

  assign pcp_ok = tag_seen && (idx_cur == IDX_W'(PCP_POS));

  always_comb begin
    res_d.mgmt = mgmt_hit;
    if (mgmt_hit)    res_d.cls = tc_class_t'(NUM_CLASSES - 1);
    else if (pcp_ok) res_d.cls = in_data[BYTE_W-1 -: CLASS_W];
    else             res_d.cls = default_prio;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= final_byte;
      if (final_byte) res_q <= res_d;
    end
  end

  assign tc_class = res_q.cls;
  assign tc_mgmt  = res_q.mgmt;
  assign tc_done  = done_q;

  assert_untagged_default_R5_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (final_byte && !mgmt_hit && !tag_seen) |=> (tc_class == $past(default_prio)));
endmodule

// File: rtl/tcc_classifier.sv
module tcc_classifier
  import tcc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int TAG_BYTES = 2,
  parameter int TAG_POS = 12,
  parameter int PREFIX_BYTES = 3,
  parameter int NUM_PREFIX = 2,
  parameter logic [NUM_PREFIX*PREFIX_BYTES*BYTE_W-1:0] PREFIX_TABLE = {24'h01_19_1B, 24'h01_80_C2},
  localparam int PCP_POS = TAG_POS + TAG_BYTES,
  localparam int IDX_W = $clog2(PCP_POS + 1),
  localparam int TAG_W = TAG_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [TAG_W-1:0]  tpid_cfg,
  input  logic [CLASS_W-1:0] default_prio,
  output logic [CLASS_W-1:0] tc_class,
  output logic              tc_mgmt,
  output logic              tc_done
);
  logic             accept;
  logic [IDX_W-1:0] idx_cur;
  logic             byte_live;
  logic             final_byte;
  logic             mgmt_hit;
  logic             tag_seen;

  assign in_ready = 1'b1;
  assign accept   = in_valid && in_ready;

  tcc_byte_tracker #(.LAST_POS(PCP_POS)) u_track (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sof(in_sof), .eof(in_eof),
    .idx_cur(idx_cur), .byte_live(byte_live), .final_byte(final_byte)
  );

  tcc_mgmt_match #(
    .BYTE_W(BYTE_W), .PREFIX_BYTES(PREFIX_BYTES), .NUM_PREFIX(NUM_PREFIX),
    .PREFIX_TABLE(PREFIX_TABLE), .IDX_W(IDX_W)
  ) u_mgmt (
    .clk(clk), .rst_n(rst_n), .byte_live(byte_live), .idx_cur(idx_cur),
    .in_data(in_data), .match_now(mgmt_hit)
  );

  tcc_tag_detect #(
    .BYTE_W(BYTE_W), .TAG_BYTES(TAG_BYTES), .TAG_POS(TAG_POS), .IDX_W(IDX_W)
  ) u_tag (
    .clk(clk), .rst_n(rst_n), .byte_live(byte_live), .idx_cur(idx_cur),
    .in_data(in_data), .tpid_cfg(tpid_cfg), .tag_seen(tag_seen)
  );

  tcc_resolver #(.BYTE_W(BYTE_W), .PCP_POS(PCP_POS), .IDX_W(IDX_W)) u_res (
    .clk(clk), .rst_n(rst_n), .final_byte(final_byte), .idx_cur(idx_cur),
    .in_data(in_data), .mgmt_hit(mgmt_hit), .tag_seen(tag_seen),
    .default_prio(default_prio), .tc_class(tc_class), .tc_mgmt(tc_mgmt),
    .tc_done(tc_done)
  );

  assert_done_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tc_done |-> $past(in_valid));
endmodule

// File: tb/tb_tcc_classifier.sv
module tb_tcc_classifier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic [15:0] tpid_cfg = 16'h8100;
  logic [2:0]  default_prio = 3'd0;
  logic [2:0]  tc_class;
  logic        tc_mgmt;
  logic        tc_done;

  int checks = 0;
  int fails = 0;
  logic [7:0] fb [0:47];
  bit         pend = 0;
  logic [2:0] pend_cls = '0;
  bit         pend_mg = 0;
  string      pend_req = "";
  logic [2:0] last_cls = '0;
  bit         last_mg = 0;

  always #10 clk = ~clk;

  tcc_classifier dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .tpid_cfg(tpid_cfg),
    .default_prio(default_prio), .tc_class(tc_class), .tc_mgmt(tc_mgmt),
    .tc_done(tc_done)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_mgmt(int len);
    if (len < 3) return 0;
    return (fb[0] == 8'h01 && fb[1] == 8'h80 && fb[2] == 8'hC2) ||
           (fb[0] == 8'h01 && fb[1] == 8'h19 && fb[2] == 8'h1B);
  endfunction

  function automatic logic [2:0] exp_class(int len);
    if (is_mgmt(len)) return 3'd7;
    if (len >= 15 && fb[12] == tpid_cfg[15:8] && fb[13] == tpid_cfg[7:0])
      return fb[14][7:5];
    return default_prio;
  endfunction

  // Check outputs at a falling edge, then clear the pending strobe.
  task automatic tick();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    if (pend) begin
      chk(tc_done == 1'b1, "R3", tc_done, 1);
      chk(tc_class == pend_cls, pend_req, tc_class, pend_cls);
      chk(tc_mgmt == pend_mg, "R6", tc_mgmt, pend_mg);
      last_cls = pend_cls;
      last_mg  = pend_mg;
      pend = 0;
    end else begin
      chk(tc_done == 1'b0, "R3", tc_done, 0);
      chk(tc_class == last_cls && tc_mgmt == last_mg, "R8", tc_class, last_cls);
    end
  endtask

  task automatic build(int len, int mg, bit tag, logic [15:0] t, logic [2:0] pcp);
    for (int i = 0; i < 48; i++) fb[i] = 8'($urandom);
    if (fb[0] == 8'h01) fb[0] = 8'h03;
    if (mg == 1) begin fb[0] = 8'h01; fb[1] = 8'h80; fb[2] = 8'hC2; end
    if (mg == 2) begin fb[0] = 8'h01; fb[1] = 8'h19; fb[2] = 8'h1B; end
    if (tag) begin fb[12] = t[15:8]; fb[13] = t[7:0]; fb[14] = {pcp, 5'h0A}; end
  endtask

  task automatic run_frame(int len, bit with_eof, int gap_max, string req);
    int fin;
    logic [2:0] ec;
    bit em;
    ec  = exp_class(len);
    em  = is_mgmt(len);
    fin = (len - 1 < 14) ? len - 1 : 14;
    if (!with_eof && len < 15) fin = -1;
    for (int i = 0; i < len; i++) begin
      for (int g = $urandom_range(0, gap_max); g > 0; g--) begin
        tick();
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
      tick();
      in_valid = 1'b1;
      in_data  = fb[i];
      in_sof   = (i == 0);
      in_eof   = with_eof && (i == len - 1);
      if (i == fin) begin
        pend = 1; pend_cls = ec; pend_mg = em; pend_req = req;
      end
    end
    tick();
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  initial begin
    #4000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(tc_done == 0 && tc_class == 0 && tc_mgmt == 0, "R8", {tc_done, tc_class, tc_mgmt}, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    rst_n = 1'b1;
    default_prio = 3'd2;

    // R4: standard tag, priority 5
    build(20, 0, 1, 16'h8100, 3'd5); run_frame(20, 1, 0, "R4");
    // R5: standard tag while custom programmed -> default
    tpid_cfg = 16'hDADA;
    build(20, 0, 1, 16'h8100, 3'd5); run_frame(20, 1, 1, "R5");
    // R4: custom tag recognised
    build(18, 0, 1, 16'hDADA, 3'd3); run_frame(18, 1, 2, "R4");
    // R6: management prefix overrides tag priority
    build(25, 1, 1, 16'hDADA, 3'd1); run_frame(25, 1, 0, "R6");
    // R7: short management frame, second prefix
    build(4, 2, 0, 16'h0, 3'd0); run_frame(4, 1, 0, "R7");
    // R7: exactly 3 matching bytes
    build(3, 1, 0, 16'h0, 3'd0); run_frame(3, 1, 1, "R7");
    // R7: partial prefix only, 2 bytes -> default
    build(2, 1, 0, 16'h0, 3'd0); run_frame(2, 1, 0, "R7");
    // R6: near-miss prefix, tagged -> priority, not management
    build(16, 1, 1, 16'hDADA, 3'd6); fb[2] = 8'hC3; run_frame(16, 1, 0, "R6");
    // R4: length exactly 15, tagged
    build(15, 0, 1, 16'hDADA, 3'd4); run_frame(15, 1, 0, "R4");
    // R7: length 14 ends before priority byte
    build(14, 0, 1, 16'hDADA, 3'd4); run_frame(14, 1, 0, "R7");
    // R7: single-byte frame
    default_prio = 3'd6;
    build(1, 0, 0, 16'h0, 3'd0); run_frame(1, 1, 0, "R7");
    // R9: abandoned frame (no eof, short) followed by a full frame
    build(8, 1, 0, 16'h0, 3'd0); run_frame(8, 0, 0, "R9");
    build(17, 0, 1, 16'hDADA, 3'd1); run_frame(17, 1, 0, "R9");
    // R2: stray valid bytes with no open frame produce no strobe
    for (int i = 0; i < 6; i++) begin
      tick();
      in_valid = 1'b1; in_data = 8'h01; in_sof = 1'b0; in_eof = (i == 5);
    end
    tick();
    in_valid = 1'b0; in_eof = 1'b0;
    tick();
    chk(tc_class == last_cls, "R2", tc_class, last_cls);

    // Random mix
    for (int n = 0; n < 200; n++) begin
      int len;
      int mg;
      bit tg;
      logic [15:0] t;
      tpid_cfg = ($urandom_range(0, 1) == 1) ? 16'h8100 : 16'h88A8;
      default_prio = 3'($urandom);
      len = $urandom_range(1, 40);
      mg  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 2)) : 0;
      tg  = ($urandom_range(0, 1) == 1);
      t   = ($urandom_range(0, 3) == 0) ? 16'h9100 : tpid_cfg;
      build(len, mg, tg, t, 3'($urandom));
      run_frame(len, ($urandom_range(0, 7) != 0), 2, mg != 0 ? "R6" : (tg ? "R4" : "R5"));
    end
    repeat (3) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule